// File: doc/BRIEF.md
# NAND Flash Command Decoder

A device-side model of a byte-wide NAND flash command interface, reduced in size so that it can be built and simulated. The block samples the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins on its own clock. Each bus byte is routed into a command register, an address collector or a page register. Two-byte command framings drive page reads, page programs, block erases and in-page column moves against a small array of blocks and pages held in flops.

A host places a setup code on the bus, then the address bytes, then optional data, then the confirm code. Address cycles are always ordered as two column bytes followed by one row byte. Only the first column byte is used, and the second is accepted but ignored. In the row byte, the low `PG_W` bits select the page and the next `BLK_W` bits select the block. After a read, program or erase confirm, the ready/busy pin stays low for a fixed number of clocks. The host can poll a status byte at any time.

Top module: `nand_cmd_dec`

## Requirements
- R1: A byte on `io_i` is taken at the first clock after `we_ni` rises while `ce_ni` is low. With `cle_i` high alone it is a command, with `ale_i` high alone an address, and with both low it is data. With both high, or with `ce_ni` high, the byte is dropped.
- R2: The read sequence is 00h, then column, column, row, then 30h. It copies the whole addressed page, including spare bytes, into the page register. After busy ends, each `re_ni` falling edge puts the byte at the column pointer on `io_o` and increments the pointer. Columns at or beyond the page size read as FFh.
- R3: The program sequence is 80h, then column, column, row, then data bytes, then 10h. 80h fills the page register with FFh, and each data byte is stored at the column pointer, which then increments. On 10h the array page becomes its old value AND the page register.
- R4: The erase sequence is 60h, then exactly one row byte, then D0h. It sets every byte of every page in the block selected by the row byte to FFh.
- R5: Accepting 30h, 10h or D0h drives `rb_no` low for exactly `BUSY_CYC` clocks, starting at the clock that takes the confirm byte.
- R6: While busy, only 70h and FFh take effect. Every other command, address byte and data byte is dropped.
- R7: A confirm code (30h, 10h, D0h or E0h) whose setup code or full address is missing starts nothing, returns the decoder to idle and leaves `rb_no` high. 85h outside the program data phase does the same.
- R8: 70h selects status output, and `io_o` then shows the live status byte. Bit 7 equals `wp_ni`, bit 6 is 1 when ready, and bit 0 is 1 when the last program or erase failed. All other bits are 0.
- R9: A program or erase confirmed while `wp_ni` is low leaves the array unchanged and sets status bit 0. A program or erase with `wp_ni` high clears that bit.
- R10: The sequence 05h, then column, column, then E0h moves the read column pointer without reloading the page and without asserting busy.
- R11: Inside the program data phase, 85h followed by column, column moves the input column pointer. Bytes already stored in the page register are kept.
- R12: FFh ends busy at once, clears status bit 0 and returns the decoder to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | sampling clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ce_ni | input | 1 | chip enable, active low |
| cle_i | input | 1 | command latch enable |
| ale_i | input | 1 | address latch enable |
| we_ni | input | 1 | write strobe, active low, byte taken on rise |
| re_ni | input | 1 | read strobe, active low, byte advanced on fall |
| wp_ni | input | 1 | write protect, active low |
| io_i | input | 8 | bus byte from host |
| io_o | output | 8 | bus byte to host |
| io_oe_o | output | 1 | host may sample `io_o` (read or status mode, CE and RE low) |
| rb_no | output | 1 | ready (1) or busy (0) |

## Verification
The assertions assume the host is well behaved at the pins. It never lowers `we_ni` and `re_ni` together. Each strobe level lasts at least one clock. Pins are driven away from the sampling edge. `BUSY_CYC` is at least one, so the row register does not move in the clock after an array operation. The bench drives every pin at the falling clock edge and holds each strobe level for a whole clock. It issues one bus cycle at a time, so both the random program, erase and read mix and the directed corner cases stay inside these limits.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;
  localparam logic [7:0] CMD_RD    = 8'h00;
  localparam logic [7:0] CMD_RD_GO = 8'h30;
  localparam logic [7:0] CMD_PG    = 8'h80;
  localparam logic [7:0] CMD_PG_GO = 8'h10;
  localparam logic [7:0] CMD_ER    = 8'h60;
  localparam logic [7:0] CMD_ER_GO = 8'hD0;
  localparam logic [7:0] CMD_RO    = 8'h05;
  localparam logic [7:0] CMD_RO_GO = 8'hE0;
  localparam logic [7:0] CMD_RI    = 8'h85;
  localparam logic [7:0] CMD_STAT  = 8'h70;
  localparam logic [7:0] CMD_RST   = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_ADR, ST_PG_ADR, ST_PG_DAT, ST_ER_ADR,
    ST_RO_ADR, ST_RI_ADR, ST_DOUT, ST_STAT
  } state_e;
endpackage

// File: rtl/nand_bus_edge.sv
module nand_bus_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic cle_i,
  input  logic ale_i,
  input  logic we_ni,
  input  logic re_ni,
  output logic cmd_stb_o,
  output logic adr_stb_o,
  output logic din_stb_o,
  output logic rd_stb_o
);
  logic we_q, re_q, we_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_ni;
      re_q <= re_ni;
    end
  end

  assign we_rise   = ~ce_ni & we_ni & ~we_q;
  assign cmd_stb_o = we_rise & cle_i & ~ale_i;
  assign adr_stb_o = we_rise & ale_i & ~cle_i;
  assign din_stb_o = we_rise & ~ale_i & ~cle_i;
  assign rd_stb_o  = ~ce_ni & ~re_ni & re_q;
endmodule

// File: rtl/nand_page_array.sv
module nand_page_array #(
  parameter int unsigned PAGE_BYTES = 10,
  parameter int unsigned ROW_W      = 4,
  parameter int unsigned PG_W       = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ROW_W-1:0]           row_i,
  input  logic [PAGE_BYTES-1:0][7:0] wr_page_i,
  input  logic                       pg_i,
  input  logic                       er_i,
  output logic [PAGE_BYTES-1:0][7:0] rd_page_o
);
  localparam int unsigned ROWS = 1 << ROW_W;

  logic [PAGE_BYTES-1:0][7:0] rows_w [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [ROW_W-1:0] RID = ROW_W'(r);
    logic [PAGE_BYTES-1:0][7:0] pg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                           pg_q <= '1;
      else if (pg_i && row_i == RID)                         pg_q <= pg_q & wr_page_i;
      else if (er_i && row_i[ROW_W-1:PG_W] == RID[ROW_W-1:PG_W]) pg_q <= '1;
    end
    assign rows_w[r] = pg_q;
  end

  assign rd_page_o = rows_w[row_i];

  AST_PROG_AND_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_i |=> rd_page_o == $past(rd_page_o & wr_page_i)); // R3
  AST_ERASE_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    er_i |=> rd_page_o == '1); // R4
endmodule

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
  import nand_cmd_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 10,
  parameter int unsigned ROW_W      = 4,
  parameter int unsigned BUSY_CYC   = 20
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_stb_i,
  input  logic                       adr_stb_i,
  input  logic                       din_stb_i,
  input  logic                       rd_stb_i,
  input  logic [7:0]                 byte_i,
  input  logic                       wp_ni,
  input  logic                       ce_ni,
  input  logic                       re_ni,
  input  logic [PAGE_BYTES-1:0][7:0] rd_page_i,
  output logic [PAGE_BYTES-1:0][7:0] wr_page_o,
  output logic [ROW_W-1:0]           row_o,
  output logic                       pg_o,
  output logic                       er_o,
  output logic [7:0]                 io_o,
  output logic                       io_oe_o,
  output logic                       rb_no
);
  localparam int unsigned COL_W  = $clog2(PAGE_BYTES);
  localparam int unsigned BCNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [7:0]        PB8     = 8'(PAGE_BYTES);
  localparam logic [BCNT_W-1:0] BUSY_LD = BCNT_W'(BUSY_CYC);

  state_e                     st_q;
  logic [1:0]                 acnt_q;
  logic [7:0]                 col_q, col_lat_q, dout_q, status;
  logic [ROW_W-1:0]           row_q;
  logic [BCNT_W-1:0]          bcnt_q;
  logic                       fail_q;
  logic [PAGE_BYTES-1:0][7:0] preg_q;
  logic                       busy, cmd_ok, col_ok, go_rd, go_pg, go_er;

  assign busy   = bcnt_q != '0;
  assign cmd_ok = cmd_stb_i & ~busy;
  assign col_ok = col_q < PB8;
  assign go_rd  = cmd_ok & (byte_i == CMD_RD_GO) & (st_q == ST_RD_ADR) & (acnt_q == 2'd3);
  assign go_pg  = cmd_ok & (byte_i == CMD_PG_GO) & (st_q == ST_PG_DAT);
  assign go_er  = cmd_ok & (byte_i == CMD_ER_GO) & (st_q == ST_ER_ADR) & (acnt_q == 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; acnt_q <= '0; col_q <= '0; col_lat_q <= '0; dout_q <= 8'hFF;
      row_q <= '0; bcnt_q <= '0; fail_q <= 1'b0; preg_q <= '1;
    end else begin
      if (busy) bcnt_q <= bcnt_q - 1'b1;
      if (cmd_stb_i && busy) begin
        if (byte_i == CMD_STAT) st_q <= ST_STAT;
        else if (byte_i == CMD_RST) begin
          st_q <= ST_IDLE; bcnt_q <= '0; fail_q <= 1'b0;
        end
      end else if (cmd_stb_i) begin
        acnt_q <= '0;
        case (byte_i)
          CMD_RD:   st_q <= ST_RD_ADR;
          CMD_PG:   begin st_q <= ST_PG_ADR; preg_q <= '1; end
          CMD_ER:   st_q <= ST_ER_ADR;
          CMD_RO:   st_q <= ST_RO_ADR;
          CMD_RI:   st_q <= (st_q == ST_PG_DAT) ? ST_RI_ADR : ST_IDLE;
          CMD_STAT: st_q <= ST_STAT;
          CMD_RST:  begin st_q <= ST_IDLE; fail_q <= 1'b0; end
          CMD_RD_GO:
            if (go_rd) begin
              preg_q <= rd_page_i; col_q <= col_lat_q; st_q <= ST_DOUT; bcnt_q <= BUSY_LD;
            end else st_q <= ST_IDLE;
          CMD_RO_GO:
            if (st_q == ST_RO_ADR && acnt_q == 2'd2) begin
              col_q <= col_lat_q; st_q <= ST_DOUT;
            end else st_q <= ST_IDLE;
          default: begin
            st_q <= ST_IDLE;
            if (go_pg || go_er) begin
              bcnt_q <= BUSY_LD; fail_q <= ~wp_ni;
            end
          end
        endcase
      end else if (adr_stb_i && !busy) begin
        if (acnt_q != 2'd3) acnt_q <= acnt_q + 1'b1;
        case (st_q)
          ST_RD_ADR, ST_PG_ADR: begin
            if (acnt_q == 2'd0) col_lat_q <= byte_i;
            if (acnt_q == 2'd2) row_q <= byte_i[ROW_W-1:0];
            if (acnt_q == 2'd2 && st_q == ST_PG_ADR) begin
              st_q <= ST_PG_DAT; col_q <= col_lat_q;
            end
          end
          ST_ER_ADR: if (acnt_q == 2'd0) row_q <= byte_i[ROW_W-1:0];
          ST_RO_ADR, ST_RI_ADR: begin
            if (acnt_q == 2'd0) col_lat_q <= byte_i;
            if (acnt_q == 2'd1 && st_q == ST_RI_ADR) begin
              st_q <= ST_PG_DAT; col_q <= col_lat_q;
            end
          end
          default: ;
        endcase
      end else if (din_stb_i && !busy && st_q == ST_PG_DAT) begin
        if (col_ok) preg_q[col_q[COL_W-1:0]] <= byte_i;
        if (col_q != 8'hFF) col_q <= col_q + 1'b1;
      end else if (rd_stb_i && !busy && st_q == ST_DOUT) begin
        dout_q <= col_ok ? preg_q[col_q[COL_W-1:0]] : 8'hFF;
        if (col_q != 8'hFF) col_q <= col_q + 1'b1;
      end
    end
  end

  assign status    = {wp_ni, ~busy, 5'b0, fail_q};
  assign io_o      = (st_q == ST_STAT) ? status : dout_q;
  assign io_oe_o   = ~ce_ni & ~re_ni & ((st_q == ST_DOUT) | (st_q == ST_STAT));
  assign rb_no     = ~busy;
  assign wr_page_o = preg_q;
  assign row_o     = row_q;
  assign pg_o      = go_pg & wp_ni;
  assign er_o      = go_er & wp_ni;

  AST_BUSY_FROM_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rb_no) |-> $past(cmd_stb_i && (byte_i == CMD_RD_GO || byte_i == CMD_PG_GO
                                         || byte_i == CMD_ER_GO))); // R5
  AST_BUSY_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rb_no && cmd_stb_i && byte_i != CMD_STAT && byte_i != CMD_RST) |=> st_q == $past(st_q)); // R6
  AST_COL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && rb_no && st_q == ST_DOUT && col_q != 8'hFF) |=> col_q == $past(col_q) + 8'd1); // R2
  AST_ORPHAN_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb_i && rb_no && byte_i == CMD_PG_GO && st_q != ST_PG_DAT) |=> (st_q == ST_IDLE && rb_no)); // R7
endmodule

// File: rtl/nand_cmd_dec.sv
module nand_cmd_dec #(
  parameter int unsigned DATA_BYTES    = 8,
  parameter int unsigned SPARE_BYTES   = 2,
  parameter int unsigned PAGES_PER_BLK = 4,
  parameter int unsigned NUM_BLKS      = 4,
  parameter int unsigned BUSY_CYC      = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_ni,
  input  logic       re_ni,
  input  logic       wp_ni,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       io_oe_o,
  output logic       rb_no
);
  localparam int unsigned PAGE_BYTES = DATA_BYTES + SPARE_BYTES;
  localparam int unsigned PG_W       = $clog2(PAGES_PER_BLK);
  localparam int unsigned BLK_W      = $clog2(NUM_BLKS);
  localparam int unsigned ROW_W      = PG_W + BLK_W;

  logic                       cmd_stb, adr_stb, din_stb, rd_stb, pg, er;
  logic [ROW_W-1:0]           row;
  logic [PAGE_BYTES-1:0][7:0] rd_page, wr_page;

  nand_bus_edge u_edge (
    .clk_i, .rst_ni, .ce_ni, .cle_i, .ale_i, .we_ni, .re_ni,
    .cmd_stb_o(cmd_stb), .adr_stb_o(adr_stb), .din_stb_o(din_stb), .rd_stb_o(rd_stb)
  );

  nand_cmd_fsm #(.PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W), .BUSY_CYC(BUSY_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .cmd_stb_i(cmd_stb), .adr_stb_i(adr_stb), .din_stb_i(din_stb), .rd_stb_i(rd_stb),
    .byte_i(io_i), .wp_ni, .ce_ni, .re_ni,
    .rd_page_i(rd_page), .wr_page_o(wr_page), .row_o(row), .pg_o(pg), .er_o(er),
    .io_o, .io_oe_o, .rb_no
  );

  nand_page_array #(.PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W), .PG_W(PG_W)) u_array (
    .clk_i, .rst_ni, .row_i(row), .wr_page_i(wr_page), .pg_i(pg), .er_i(er),
    .rd_page_o(rd_page)
  );
endmodule

// File: tb/nand_cmd_dec_test.sv
module nand_cmd_dec_test;
  localparam int PB    = 10;
  localparam int PPB   = 4;
  localparam int NBLK  = 4;
  localparam int ROWS  = PPB * NBLK;
  localparam int BUSY  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic       io_oe, rb_n;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] model [ROWS][PB];
  logic [7:0] pbuf [PB];
  logic       m_fail = 1'b0;

  always #2 clk = ~clk;

  nand_cmd_dec #(.DATA_BYTES(8), .SPARE_BYTES(2), .PAGES_PER_BLK(PPB),
                 .NUM_BLKS(NBLK), .BUSY_CYC(BUSY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .we_ni(we_n), .re_ni(re_n), .wp_ni(wp_n), .io_i(io_in),
    .io_o(io_out), .io_oe_o(io_oe), .rb_no(rb_n)
  );

  function automatic logic [7:0] f_status(logic wp, logic rdy, logic fl);
    return {wp, rdy, 5'b0, fl};
  endfunction

  function automatic void model_prog(int row);
    for (int i = 0; i < PB; i++) model[row][i] = model[row][i] & pbuf[i];
  endfunction

  function automatic void model_erase(int blk);
    for (int p = 0; p < PPB; p++)
      for (int i = 0; i < PB; i++) model[blk*PPB+p][i] = 8'hFF;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic c, logic cl, logic al, logic [7:0] b);
    @(negedge clk);
    ce_n = c; cle = cl; ale = al; io_in = b; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  task automatic cmd(logic [7:0] b); bus_wr(1'b0, 1'b1, 1'b0, b); endtask
  task automatic adr(logic [7:0] b); bus_wr(1'b0, 1'b0, 1'b1, b); endtask
  task automatic din(logic [7:0] b); bus_wr(1'b0, 1'b0, 1'b0, b); endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); v = io_out; re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rb_n && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic do_read(int row, int col0, string tag);
    int n; logic [7:0] v;
    cmd(8'h00); adr(8'(col0)); adr(8'h00); adr(8'(row)); cmd(8'h30);
    wait_rdy(n);
    chk("R5 read busy length", n, BUSY);
    for (int i = col0; i < PB; i++) begin
      rd(v);
      chk(tag, v, model[row][i]);
    end
  endtask

  task automatic do_prog(int row);
    int n;
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'(row));
    for (int i = 0; i < PB; i++) din(pbuf[i]);
    cmd(8'h10);
    wait_rdy(n);
    chk("R5 program busy length", n, BUSY);
    if (wp_n) model_prog(row);
    m_fail = ~wp_n;
  endtask

  task automatic do_erase(int blk);
    int n;
    cmd(8'h60); adr(8'(blk * PPB)); cmd(8'hD0);
    wait_rdy(n);
    chk("R5 erase busy length", n, BUSY);
    if (wp_n) model_erase(blk);
    m_fail = ~wp_n;
  endtask

  task automatic rd_status(string tag);
    logic [7:0] v;
    cmd(8'h70); rd(v);
    chk(tag, v, f_status(wp_n, rb_n, m_fail));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R5 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd7));
    for (int r = 0; r < ROWS; r++) for (int i = 0; i < PB; i++) model[r][i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R5 reset ready", rb_n, 1);
    chk("R8 reset oe low", io_oe, 0);
    rd_status("R8 reset status C0h");

    // erased page read and read-framing checks
    do_read(5, 0, "R2 erased page reads FFh");

    // R1: dropped bytes with CE high or both latch enables high
    cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'd5);
    bus_wr(1'b1, 1'b1, 1'b0, 8'h30);
    chk("R1 CE high confirm dropped", rb_n, 1);
    bus_wr(1'b0, 1'b1, 1'b1, 8'h30);
    chk("R1 CLE+ALE confirm dropped", rb_n, 1);
    cmd(8'h30);
    wait_rdy(n);
    chk("R1 valid confirm after dropped ones", n, BUSY);

    // R3: program then AND-only reprogram
    for (int i = 0; i < PB; i++) pbuf[i] = 8'(8'hA5 ^ i);
    do_prog(5);
    do_read(5, 0, "R3 program pattern");
    for (int i = 0; i < PB; i++) pbuf[i] = 8'h3C;
    do_prog(5);
    do_read(5, 0, "R3 reprogram ANDs");
    rd_status("R9 status pass after program");

    // R11: random input column move
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'd6);
    din(8'h11); din(8'h22);
    cmd(8'h85); adr(8'd7); adr(8'h00);
    din(8'h77);
    cmd(8'h10);
    wait_rdy(n);
    for (int i = 0; i < PB; i++) pbuf[i] = 8'hFF;
    pbuf[0] = 8'h11; pbuf[1] = 8'h22; pbuf[7] = 8'h77;
    model_prog(6);
    do_read(6, 0, "R11 random input page");

    // R10 + R2 out of range
    do_read(5, 0, "R2 reload row 5");
    cmd(8'h05); adr(8'd3); adr(8'h00); cmd(8'hE0);
    chk("R10 no busy on E0h", rb_n, 1);
    rd(v); chk("R10 column 3", v, model[5][3]);
    rd(v); chk("R10 column 4 increments", v, model[5][4]);
    cmd(8'h05); adr(8'(PB-1)); adr(8'h00); cmd(8'hE0);
    rd(v); chk("R2 last column", v, model[5][PB-1]);
    rd(v); chk("R2 beyond page FFh", v, 8'hFF);

    // R4: erase block 1, rows 4..7
    for (int i = 0; i < PB; i++) pbuf[i] = 8'h0F;
    do_prog(3);
    do_erase(1);
    do_read(5, 0, "R4 erased row 5");
    do_read(7, 0, "R4 erased row 7");
    do_read(3, 0, "R4 other block kept");

    // R9: write protect
    for (int i = 0; i < PB; i++) pbuf[i] = 8'h00;
    wp_n = 1'b0;
    do_prog(3);
    rd_status("R9 status fail wp low");
    chk("R8 bit7 follows wp", io_out[7], 0);
    do_read(3, 0, "R9 protected program kept");
    do_erase(0);
    do_read(3, 0, "R9 protected erase kept");
    wp_n = 1'b1;

    // R6: lockout during busy
    for (int i = 0; i < PB; i++) pbuf[i] = 8'(8'hF0 | i);
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'd9);
    for (int i = 0; i < PB; i++) din(pbuf[i]);
    cmd(8'h10);
    model_prog(9); m_fail = 1'b0;
    cmd(8'h60); adr(8'd9); cmd(8'hD0);
    cmd(8'h70); rd(v);
    chk("R8 status busy 80h", v, 8'h80);
    wait_rdy(n);
    rd(v);
    chk("R8 status ready C0h", v, 8'hC0);
    do_read(9, 0, "R6 erase during busy dropped");

    // R12: reset during busy clears fail
    wp_n = 1'b0;
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'd11); din(8'h00); cmd(8'h10);
    chk("R5 busy after confirm", rb_n, 0);
    cmd(8'hFF);
    chk("R12 reset ends busy", rb_n, 1);
    wp_n = 1'b1; m_fail = 1'b0;
    rd_status("R12 fail cleared");
    do_read(11, 0, "R9 row 11 kept");

    // R7: orphan confirms
    cmd(8'h10); chk("R7 lone 10h", rb_n, 1);
    cmd(8'hD0); chk("R7 lone D0h", rb_n, 1);
    cmd(8'h30); chk("R7 lone 30h", rb_n, 1);
    cmd(8'h85); cmd(8'h10); chk("R7 85h outside program", rb_n, 1);
    cmd(8'h00); adr(8'h00); cmd(8'h30); chk("R7 short address", rb_n, 1);
    cmd(8'h60); adr(8'd4); adr(8'd4); cmd(8'hD0); chk("R7 extra erase byte", rb_n, 1);
    do_read(4, 0, "R7 no erase happened");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op, row;
      op  = int'($urandom_range(0, 3));
      row = int'($urandom_range(0, ROWS - 1));
      if (op < 2) begin
        for (int i = 0; i < PB; i++) pbuf[i] = 8'($urandom) | 8'($urandom);
        do_prog(row);
      end else if (op == 2) do_erase(row / PPB);
      else do_read(row, int'($urandom_range(0, PB - 1)), "R2 random read");
    end
    for (int r = 0; r < ROWS; r++) do_read(r, 0, "R3 final array sweep");
    rd_status("R8 final status");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule